// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single address reservation that one hardware thread builds with a load-linked access and later spends with a store-conditional. A load-linked request records its physical address, rounded down to a 16-byte boundary, and arms a reservation flag. Invalidations or snoops from other agents disarm the flag when they land in the same cache block as the recorded address. The cache block size is set by a mask parameter. The default mask selects 64-byte blocks. The mask must be aligned to at least 16 bytes.

When the thread presents a store-conditional, the block decides whether the store may go to memory and returns a result code. Uncacheable store-conditionals are not checked against the reservation. They always proceed and get a distinct bypass code. Every cacheable store-conditional clears the flag, whether it passes or fails. Failed attempts are counted. A successful attempt sets the count back to zero. Each time the count reaches a nonzero multiple of the warning period, the block raises a one-cycle livelock warning.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked request records its address with bits [3:0] forced to zero and arms the flag. A later cacheable store-conditional to any byte of that 16-byte region passes.
- R2: While the flag is armed, a snoop whose address matches the recorded address under BLOCK_MASK disarms the flag. A snoop to a different block leaves the flag armed.
- R3: An uncacheable store-conditional gives go=1 and code 2. It leaves both the flag and the failure count unchanged.
- R4: A cacheable store-conditional fails when the flag is disarmed, or when its address with bits [3:0] cleared differs from the recorded address.
- R5: A failure gives go=0 and code 0, and disarms the flag.
- R6: A passing cacheable store-conditional gives go=1 and code 1, disarms the flag and resets the failure count to 0.
- R7: Each failed store-conditional adds one to the failure count. The new count is visible together with the decision.
- R8: When the failure count becomes a nonzero multiple of WARN_PERIOD (default 100000), the livelock warning is high for exactly one cycle.
- R9: A load-linked request and a snoop in the same cycle leave the flag armed. A snoop in the same cycle as a store-conditional is applied before the check.
- R10: dec_valid, dec_go, dec_code and livelock_warn change one clock edge after the store-conditional cycle. dec_valid is low in every other cycle.
- R11: Reset disarms the flag, clears the recorded address and the failure count, and drives all decision outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_addr | input | ADDR_W | Physical address of the load-linked access |
| snp_valid | input | 1 | Snoop or invalidate strobe |
| snp_addr | input | ADDR_W | Snooped address |
| sc_valid | input | 1 | Store-conditional check strobe |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional carries the uncacheable attribute |
| dec_valid | output | 1 | Decision valid, one cycle after sc_valid |
| dec_go | output | 1 | Store may be issued to memory |
| dec_code | output | 2 | Result code: 0 fail, 1 success, 2 uncacheable bypass |
| fail_count | output | CNT_W | Failed store-conditionals since the last success or reset |
| livelock_warn | output | 1 | One-cycle pulse at each nonzero multiple of WARN_PERIOD failures |

## Verification
All decision outputs are registered. The decision, the updated failure count and the warning pulse all appear at the clock edge that follows the cycle in which sc_valid is high. The bench drives each request on a falling edge and samples the outputs on the next falling edge, which is exactly one edge later. Flag effects are never read directly. Each load-linked request, snoop or earlier store-conditional is judged through the code returned by a following store-conditional. The warning is checked on the cycles on both sides of the 100000th consecutive failure.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Reservation granule: 16 bytes.
    localparam int GRAN_LSB = 4;

    typedef enum logic [1:0] {
        SC_FAIL   = 2'd0,
        SC_OK     = 2'd1,
        SC_BYPASS = 2'd2
    } sc_code_e;

    typedef struct packed {
        logic     go;
        sc_code_e code;
    } sc_dec_t;

endpackage

// File: rtl/llsc_resv_store.sv
module llsc_resv_store
    import llsc_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BLOCK_MASK = ~ADDR_W'(63)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              sc_clear,
    output logic              flag_q,
    output logic              flag_eff,
    output logic [ADDR_W-1:0] resv_addr
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~ADDR_W'((1 << GRAN_LSB) - 1);

    logic snp_hit;

    // A snoop matters only while the flag is armed.
    assign snp_hit  = flag_q && snp_valid &&
                      ((snp_addr & BLOCK_MASK) == (resv_addr & BLOCK_MASK));
    // State a same-cycle store-conditional is judged against.
    assign flag_eff = flag_q && !snp_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= 1'b0;
            resv_addr <= '0;
        end else if (ll_valid) begin
            flag_q    <= 1'b1;
            resv_addr <= ll_addr & GRAN_MASK;
        end else if (sc_clear || snp_hit) begin
            flag_q    <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              sc_valid,
    input  logic              sc_uncached,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              flag_eff,
    input  logic [ADDR_W-1:0] resv_addr,
    output sc_dec_t           dec,
    output logic              clr_flag,
    output logic              sc_fail,
    output logic              sc_pass
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~ADDR_W'((1 << GRAN_LSB) - 1);

    always_comb begin
        dec      = '{go: 1'b0, code: SC_FAIL};
        clr_flag = 1'b0;
        sc_fail  = 1'b0;
        sc_pass  = 1'b0;
        if (sc_valid) begin
            if (sc_uncached) begin
                dec = '{go: 1'b1, code: SC_BYPASS};
            end else if (flag_eff && ((sc_addr & GRAN_MASK) == resv_addr)) begin
                dec      = '{go: 1'b1, code: SC_OK};
                clr_flag = 1'b1;
                sc_pass  = 1'b1;
            end else begin
                clr_flag = 1'b1;
                sc_fail  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_fail_tracker.sv
module llsc_fail_tracker #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sc_fail,
    input  logic             sc_pass,
    output logic [CNT_W-1:0] fail_count,
    output logic             warn
);
    localparam int PER_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(WARN_PERIOD - 1);

    // Counts failures within the current warning period.
    logic [PER_W-1:0] per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_count <= '0;
            per_q      <= '0;
            warn       <= 1'b0;
        end else begin
            warn <= 1'b0;
            if (sc_pass) begin
                fail_count <= '0;
                per_q      <= '0;
            end else if (sc_fail) begin
                fail_count <= fail_count + 1'b1;
                if (per_q == PER_LAST) begin
                    per_q <= '0;
                    warn  <= 1'b1;
                end else begin
                    per_q <= per_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
    import llsc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BLOCK_MASK  = ~ADDR_W'(63),
    parameter int                CNT_W       = 32,
    parameter int                WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_uncached,
    output logic              dec_valid,
    output logic              dec_go,
    output logic [1:0]        dec_code,
    output logic [CNT_W-1:0]  fail_count,
    output logic              livelock_warn
);
    logic              resv_flag;
    logic              flag_eff;
    logic [ADDR_W-1:0] resv_addr;
    sc_dec_t           dec_n;
    sc_dec_t           dec_q;
    logic              clr_flag;
    logic              sc_fail;
    logic              sc_pass;

    llsc_resv_store #(.ADDR_W(ADDR_W), .BLOCK_MASK(BLOCK_MASK)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ll_valid  (ll_valid),
        .ll_addr   (ll_addr),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .sc_clear  (clr_flag),
        .flag_q    (resv_flag),
        .flag_eff  (flag_eff),
        .resv_addr (resv_addr)
    );

    llsc_sc_judge #(.ADDR_W(ADDR_W)) u_judge (
        .sc_valid    (sc_valid),
        .sc_uncached (sc_uncached),
        .sc_addr     (sc_addr),
        .flag_eff    (flag_eff),
        .resv_addr   (resv_addr),
        .dec         (dec_n),
        .clr_flag    (clr_flag),
        .sc_fail     (sc_fail),
        .sc_pass     (sc_pass)
    );

    llsc_fail_tracker #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_track (
        .clk        (clk),
        .rst        (rst),
        .sc_fail    (sc_fail),
        .sc_pass    (sc_pass),
        .fail_count (fail_count),
        .warn       (livelock_warn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_q     <= '{go: 1'b0, code: SC_FAIL};
        end else begin
            dec_valid <= sc_valid;
            dec_q     <= dec_n;
        end
    end

    assign dec_go   = dec_q.go;
    assign dec_code = dec_q.code;

endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ll_valid,
    input logic             sc_valid,
    input logic             sc_uncached,
    input logic             dec_valid,
    input logic             dec_go,
    input logic [1:0]       dec_code,
    input logic [CNT_W-1:0] fail_count,
    input logic             livelock_warn,
    input logic             resv_flag
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> dec_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |=> !dec_valid);
    p_bypass_code_r3: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && sc_uncached) |=> (dec_go && dec_code == 2'd2));
    p_bypass_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && sc_uncached) |=> $stable(fail_count));
    p_fail_no_go_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_code == 2'd0) |-> !dec_go);
    p_arm_on_ll_r1: assert property (@(posedge clk) disable iff (rst)
        ll_valid |=> resv_flag);
    p_sc_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !sc_uncached && !ll_valid) |=> !resv_flag);
    p_fail_counts_r7: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !sc_uncached) |=> (dec_code == 2'd0) ==
                                       (fail_count == $past(fail_count) + 1'b1));
    p_pass_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_code == 2'd1) |-> fail_count == '0);
    p_warn_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |=> !livelock_warn);
    p_warn_on_fail_r8: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |-> (dec_valid && dec_code == 2'd0 && fail_count != '0));

endmodule

bind llsc_resv_monitor llsc_resv_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ll_valid      (ll_valid),
    .sc_valid      (sc_valid),
    .sc_uncached   (sc_uncached),
    .dec_valid     (dec_valid),
    .dec_go        (dec_go),
    .dec_code      (dec_code),
    .fail_count    (fail_count),
    .livelock_warn (livelock_warn),
    .resv_flag     (resv_flag)
);

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 32;
    localparam int WARN_P     = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ll_valid = 1'b0;
    logic [ADDR_W-1:0] ll_addr = '0;
    logic              snp_valid = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              sc_valid = 1'b0;
    logic [ADDR_W-1:0] sc_addr = '0;
    logic              sc_uncached = 1'b0;
    logic              dec_valid;
    logic              dec_go;
    logic [1:0]        dec_code;
    logic [CNT_W-1:0]  fail_count;
    logic              livelock_warn;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_resv_monitor u_dut (
        .clk(clk), .rst(rst),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
        .dec_valid(dec_valid), .dec_go(dec_go), .dec_code(dec_code),
        .fail_count(fail_count), .livelock_warn(livelock_warn)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One idle cycle; the decision strobe must stay low (R10).
    task automatic idle_cycle();
        @(negedge clk);
        check("R10 idle dec_valid", dec_valid, 0);
    endtask

    task automatic do_ll(input logic [ADDR_W-1:0] a, input logic snp, input logic [ADDR_W-1:0] sa);
        ll_valid = 1'b1; ll_addr = a; snp_valid = snp; snp_addr = sa;
        @(negedge clk);
        ll_valid = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic [ADDR_W-1:0] sa);
        snp_valid = 1'b1; snp_addr = sa;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Store-conditional with optional same-cycle snoop, checked one edge later.
    task automatic do_sc(input string req, input logic [ADDR_W-1:0] a, input logic unc,
                         input logic snp, input logic [ADDR_W-1:0] sa, input int exp_code);
        sc_valid = 1'b1; sc_addr = a; sc_uncached = unc; snp_valid = snp; snp_addr = sa;
        @(negedge clk);
        sc_valid = 1'b0; sc_uncached = 1'b0; snp_valid = 1'b0;
        if (exp_code == 0) exp_cnt++;
        else if (exp_code == 1) exp_cnt = 0;
        check({req, " R10 dec_valid"}, dec_valid, 1);
        check({req, " code"}, dec_code, exp_code);
        check({req, " go"}, dec_go, (exp_code != 0) ? 1 : 0);
        check({req, " R7 count"}, fail_count, exp_cnt);
        check({req, " R8 no warn"}, livelock_warn, 0);
    endtask

    task automatic t_reset();
        check("R11 dec_valid", dec_valid, 0);
        check("R11 go", dec_go, 0);
        check("R11 count", fail_count, 0);
        check("R11 warn", livelock_warn, 0);
        do_sc("R4 flag clear after reset", 32'h0, 0, 0, 0, 0);
    endtask

    task automatic t_ll_pass();
        do_ll(32'h1234_5678, 0, 0);
        do_sc("R1/R6 pass in granule", 32'h1234_567C, 0, 0, 0, 1);
        do_sc("R5/R6 pass disarms", 32'h1234_5670, 0, 0, 0, 0);
        idle_cycle();
    endtask

    task automatic t_mismatch();
        do_ll(32'h0000_1000, 0, 0);
        do_sc("R4 next granule fails", 32'h0000_1010, 0, 0, 0, 0);
        do_sc("R5 failure disarms", 32'h0000_1000, 0, 0, 0, 0);
    endtask

    task automatic t_snoop();
        do_ll(32'h0000_2000, 0, 0);
        do_snoop(32'h0000_2030);
        do_sc("R2 same-block snoop kills", 32'h0000_2000, 0, 0, 0, 0);
        do_ll(32'h0000_2000, 0, 0);
        do_snoop(32'h0000_2040);
        do_sc("R2 other-block snoop ignored", 32'h0000_2000, 0, 0, 0, 1);
    endtask

    task automatic t_uncached();
        do_sc("R4 fail before bypass", 32'h0000_3000, 0, 0, 0, 0);
        do_ll(32'h0000_3000, 0, 0);
        do_sc("R3 bypass", 32'h0000_9990, 1, 0, 0, 2);
        do_sc("R3 flag kept after bypass", 32'h0000_3008, 0, 0, 0, 1);
    endtask

    task automatic t_same_cycle();
        do_ll(32'h0000_4000, 1, 32'h0000_4000);
        do_sc("R9 ll beats snoop", 32'h0000_4000, 0, 0, 0, 1);
        do_ll(32'h0000_5000, 0, 0);
        do_sc("R9 snoop before check", 32'h0000_5000, 0, 1, 32'h0000_5008, 0);
    endtask

    task automatic t_reset_mid();
        do_ll(32'h0000_6000, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_cnt = 0;
        check("R11 count cleared", fail_count, 0);
        do_sc("R11 flag cleared", 32'h0000_6000, 0, 0, 0, 0);
    endtask

    task automatic t_warn();
        int warns = 0;
        do_ll(32'h0000_7000, 0, 0);
        do_sc("R6 zero count", 32'h0000_7000, 0, 0, 0, 1);
        sc_valid = 1'b1; sc_addr = 32'h0000_7000; sc_uncached = 1'b0;
        for (int i = 1; i <= WARN_P + 1; i++) begin
            @(negedge clk);
            if (livelock_warn) warns++;
            if (i == WARN_P - 1) check("R8 no warn before period", livelock_warn, 0);
            if (i == WARN_P)     check("R8 warn at period", livelock_warn, 1);
            if (i == WARN_P + 1) check("R8 warn one cycle", livelock_warn, 0);
        end
        sc_valid = 1'b0;
        exp_cnt = WARN_P + 1;
        check("R7 count after run", fail_count, exp_cnt);
        check("R8 single pulse", warns, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ll_pass();
        t_mismatch();
        t_snoop();
        t_uncached();
        t_same_cycle();
        t_reset_mid();
        t_warn();
        idle_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule